// File: doc/BRIEF.md
# DRAM Command Ordering Arbiter

This block is the second scheduling stage of a DRAM controller. Each cycle it looks at the head command of every per-bank queue across all ranks and grants at most one of them to the command bus. Every head is a candidate with a valid flag, a command type, an age and a bank-timing ready bit. The bank-timing bit is computed outside the block and covers row-to-column and precharge timing. Inside the block, three shared constraints are tracked. The data bus stays busy for a burst after each column command. A column command to a different rank from the previous one needs extra turnaround. Each rank may receive only four activates inside a rolling window.

A two-bit policy select picks the ordering rule: strict oldest-first, bank round robin, rank round robin, or first-available. First-available checks every candidate against all constraints and grants the oldest legal one. The candidate interface is valid/ready. A queue head is offered with `cand_valid`. It is consumed in the cycle where `cand_ready` is high for it. A head that is not granted keeps its place and must be held stable by its queue. `cand_ready` depends on `cand_valid` within the same cycle; there is no buffering.

Command encoding on `cand_cmd` (two bits per candidate): 0 = activate, 1 = read, 2 = write, 3 = precharge. Candidate index i belongs to rank i / BANKS_PER_RANK and bank i % BANKS_PER_RANK. A larger age value means an older request. Policy encoding: 0 = oldest-first, 1 = bank round robin, 2 = rank round robin, 3 = first-available.

Top module: `dram_cmd_arbiter`

## Requirements
- R1: After reset there is no grant while no candidate is valid. Both round-robin pointers start at index 0 and rank 0. The column spacing and activate histories start fully elapsed.
- R2: At most one `cand_ready` bit is high per cycle. It goes only to a valid candidate whose `bank_ok` bit is high. With every `bank_ok` low, nothing is granted.
- R3: Two read/write commands are granted at least BURST_LEN cycles apart, counting from grant cycle to grant cycle.
- R4: A read/write to a rank other than the rank of the previous read/write needs at least BURST_LEN + T_RTRS cycles after that previous one.
- R5: An activate to a rank is granted only if that rank's fourth most recent activate was at least T_FAW cycles earlier. So a rank never gets more than four activates in any T_FAW-cycle window.
- R6: Policy 0 selects the oldest valid candidate, with the lowest index winning ties. If that candidate is not legal, nothing is granted.
- R7: Policy 3 grants the oldest legal candidate, with the lowest index winning ties, even when older candidates are blocked.
- R8: Policy 1 selects the first valid candidate at or after the bank pointer, wrapping around. It grants that candidate only if it is legal. After a grant the pointer moves to the granted index + 1, and it holds when there is no grant.
- R9: Policy 2 selects the first rank at or after the rank pointer that has any valid candidate. Inside that rank it takes the oldest valid candidate, lowest index on ties. It grants only if that candidate is legal. After a grant the pointer moves to the granted rank + 1.
- R10: Activates and precharges are not held back by data-bus spacing or rank turnaround. A precharge needs only its `bank_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 2 | Ordering policy (0 oldest-first, 1 bank RR, 2 rank RR, 3 first-available) |
| cand_valid | input | NQ | Queue head present, one bit per rank/bank |
| cand_cmd | input | 2*NQ | Command type per candidate |
| cand_age | input | AGE_W*NQ | Age per candidate, larger is older |
| bank_ok | input | NQ | Per-bank timing satisfied for the head command |
| cand_ready | output | NQ | One-hot grant; the head is consumed |
| issue_valid | output | 1 | A command is issued this cycle |
| issue_cmd | output | 2 | Type of the issued command |
| issue_rank | output | RK_W | Rank of the issued command |
| issue_bank | output | BK_W | Bank of the issued command |

## Verification
All state in this block shows up in the grant within the next cycle or two. A wrong column gap counter or wrong last-rank register makes a read or write appear one or more cycles early or late. A shifted activate history lets a fifth activate through, or blocks one. A pointer that advances at the wrong time sends the next round-robin grant to a different index. The bench runs a cycle-accurate model that is derived from the requirements. It compares the full `cand_ready` vector every cycle, so any such divergence is caught in the cycle it first affects a grant.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    POL_OLDEST     = 2'd0,
    POL_BANK_RR    = 2'd1,
    POL_RANK_RR    = 2'd2,
    POL_FIRST_FREE = 2'd3
  } policy_e;

  function automatic logic is_column(input logic [1:0] c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/dcs_faw_window.sv
module dcs_faw_window #(
  parameter int T_FAW = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_issue,
  output logic act_ok
);
  localparam int CW = $clog2(T_FAW + 1);
  localparam logic [CW-1:0] SAT = CW'(T_FAW);

  // elapsed cycles since each of the last four activates, newest first
  logic [CW-1:0] since_q [4];

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] x);
    return (x >= SAT) ? SAT : x + CW'(1);
  endfunction

  assign act_ok = (since_q[3] >= SAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) since_q[k] <= SAT;
    end else if (act_issue) begin
      since_q[0] <= CW'(1);
      for (int k = 1; k < 4; k++) since_q[k] <= bump(since_q[k-1]);
    end else begin
      for (int k = 0; k < 4; k++) since_q[k] <= bump(since_q[k]);
    end
  end

  // R5
  faw_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_issue |-> since_q[3] >= SAT);

  // R5
  faw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    since_q[0] <= since_q[1] && since_q[1] <= since_q[2] && since_q[2] <= since_q[3]);

endmodule

// File: rtl/dcs_bus_tracker.sv
module dcs_bus_tracker #(
  parameter int NR     = 2,
  parameter int RK_W   = 1,
  parameter int BURST  = 4,
  parameter int T_RTRS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            col_issue,
  input  logic [RK_W-1:0] col_rank,
  output logic [NR-1:0]   col_ok
);
  localparam int GMAX = BURST + T_RTRS;
  localparam int GW   = $clog2(GMAX + 1);

  logic [GW-1:0]   gap_q;
  logic [RK_W-1:0] last_rank_q;

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      if (RK_W'(r) == last_rank_q) col_ok[r] = (gap_q >= GW'(BURST));
      else                         col_ok[r] = (gap_q >= GW'(GMAX));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q       <= GW'(GMAX);
      last_rank_q <= '0;
    end else if (col_issue) begin
      gap_q       <= GW'(1);
      last_rank_q <= col_rank;
    end else if (gap_q < GW'(GMAX)) begin
      gap_q <= gap_q + GW'(1);
    end
  end

  // R3
  col_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_issue |-> gap_q >= GW'(BURST));

  // R4
  rank_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_issue && col_rank != last_rank_q) |-> gap_q >= GW'(GMAX));

endmodule

// File: rtl/dcs_pick.sv
module dcs_pick
  import dcs_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int NR    = 2,
  parameter int NB    = 4,
  parameter int AGE_W = 4,
  parameter int IDX_W = 3,
  parameter int RK_W  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  policy_e            policy,
  input  logic [NQ-1:0]      valid,
  input  logic [NQ-1:0]      legal,
  input  logic [NQ*AGE_W-1:0] ages,
  output logic [NQ-1:0]      grant,
  output logic               grant_any,
  output logic [IDX_W-1:0]   grant_idx
);
  logic [IDX_W-1:0] bptr_q;
  logic [RK_W-1:0]  rptr_q;

  logic             old_f, free_f, brr_f, rrr_f, sel_f;
  logic [IDX_W-1:0] old_i, free_i, brr_i, rrr_i, sel_i;

  always_comb begin
    logic [AGE_W-1:0] a, old_a, free_a, rrr_a;
    logic             rank_f;
    int               j, rsel;
    old_f = 1'b0;  old_i = '0;  old_a = '0;
    free_f = 1'b0; free_i = '0; free_a = '0;
    brr_f = 1'b0;  brr_i = '0;
    rrr_f = 1'b0;  rrr_i = '0;  rrr_a = '0;
    rank_f = 1'b0; rsel = 0;

    // oldest among all valid, and oldest among valid and legal
    for (int i = 0; i < NQ; i++) begin
      a = ages[i*AGE_W +: AGE_W];
      if (valid[i] && (!old_f || a > old_a)) begin
        old_f = 1'b1; old_i = IDX_W'(i); old_a = a;
      end
      if (valid[i] && legal[i] && (!free_f || a > free_a)) begin
        free_f = 1'b1; free_i = IDX_W'(i); free_a = a;
      end
    end

    // bank round robin: first valid at or after the pointer
    for (int k = 0; k < NQ; k++) begin
      j = (int'(bptr_q) + k) % NQ;
      if (!brr_f && valid[j]) begin
        brr_f = 1'b1; brr_i = IDX_W'(j);
      end
    end

    // rank round robin: first rank with work, then oldest inside it
    for (int k = 0; k < NR; k++) begin
      j = (int'(rptr_q) + k) % NR;
      if (!rank_f && (|valid[j*NB +: NB])) begin
        rank_f = 1'b1; rsel = j;
      end
    end
    for (int b = 0; b < NB; b++) begin
      j = rsel * NB + b;
      a = ages[j*AGE_W +: AGE_W];
      if (rank_f && valid[j] && (!rrr_f || a > rrr_a)) begin
        rrr_f = 1'b1; rrr_i = IDX_W'(j); rrr_a = a;
      end
    end

    case (policy)
      POL_OLDEST:  begin sel_f = old_f; sel_i = old_i; end
      POL_BANK_RR: begin sel_f = brr_f; sel_i = brr_i; end
      POL_RANK_RR: begin sel_f = rrr_f; sel_i = rrr_i; end
      default:     begin sel_f = free_f; sel_i = free_i; end
    endcase
  end

  assign grant_any = sel_f && legal[sel_i];
  assign grant_idx = sel_i;
  assign grant     = grant_any ? (NQ'(1) << sel_i) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bptr_q <= '0;
      rptr_q <= '0;
    end else if (grant_any) begin
      if (policy == POL_BANK_RR) bptr_q <= IDX_W'((int'(sel_i) + 1) % NQ);
      if (policy == POL_RANK_RR) rptr_q <= RK_W'((int'(sel_i) / NB + 1) % NR);
    end
  end

  // R8
  rr_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_any |=> $stable(bptr_q) && $stable(rptr_q));

  // R2
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any |-> valid[grant_idx] && legal[grant_idx]);

  // R7
  free_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_FIRST_FREE && |(valid & legal)) |-> grant_any);

endmodule

// File: rtl/dram_cmd_arbiter.sv
module dram_cmd_arbiter
  import dcs_pkg::*;
#(
  parameter int NUM_RANKS      = 2,
  parameter int BANKS_PER_RANK = 4,
  parameter int AGE_W          = 4,
  parameter int BURST_LEN      = 4,
  parameter int T_RTRS         = 2,
  parameter int T_FAW          = 12,
  localparam int NQ    = NUM_RANKS * BANKS_PER_RANK,
  localparam int IDX_W = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int RK_W  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BK_W  = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          policy_sel,
  input  logic [NQ-1:0]       cand_valid,
  input  logic [2*NQ-1:0]     cand_cmd,
  input  logic [AGE_W*NQ-1:0] cand_age,
  input  logic [NQ-1:0]       bank_ok,
  output logic [NQ-1:0]       cand_ready,
  output logic                issue_valid,
  output logic [1:0]          issue_cmd,
  output logic [RK_W-1:0]     issue_rank,
  output logic [BK_W-1:0]     issue_bank
);
  logic [NUM_RANKS-1:0] col_ok, act_ok, act_issue;
  logic [NQ-1:0]        legal;
  logic                 grant_any;
  logic [IDX_W-1:0]     grant_idx;
  logic                 col_issue;

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      logic [1:0] c;
      c = cand_cmd[2*i +: 2];
      if (is_column(c))       legal[i] = bank_ok[i] && col_ok[i / BANKS_PER_RANK];
      else if (c == CMD_ACT)  legal[i] = bank_ok[i] && act_ok[i / BANKS_PER_RANK];
      else                    legal[i] = bank_ok[i];
    end
  end

  dcs_pick #(
    .NQ(NQ), .NR(NUM_RANKS), .NB(BANKS_PER_RANK),
    .AGE_W(AGE_W), .IDX_W(IDX_W), .RK_W(RK_W)
  ) pick_i (
    .clk(clk), .rst_n(rst_n), .policy(policy_e'(policy_sel)),
    .valid(cand_valid), .legal(legal), .ages(cand_age),
    .grant(cand_ready), .grant_any(grant_any), .grant_idx(grant_idx)
  );

  always_comb begin
    issue_valid = grant_any;
    issue_cmd   = cand_cmd[2*int'(grant_idx) +: 2];
    issue_rank  = RK_W'(int'(grant_idx) / BANKS_PER_RANK);
    issue_bank  = BK_W'(int'(grant_idx) % BANKS_PER_RANK);
  end

  assign col_issue = grant_any && is_column(issue_cmd);

  dcs_bus_tracker #(
    .NR(NUM_RANKS), .RK_W(RK_W), .BURST(BURST_LEN), .T_RTRS(T_RTRS)
  ) bus_i (
    .clk(clk), .rst_n(rst_n), .col_issue(col_issue),
    .col_rank(issue_rank), .col_ok(col_ok)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    assign act_issue[r] = grant_any && (issue_cmd == CMD_ACT) && (int'(issue_rank) == r);
    dcs_faw_window #(.T_FAW(T_FAW)) faw_i (
      .clk(clk), .rst_n(rst_n), .act_issue(act_issue[r]), .act_ok(act_ok[r])
    );
  end

  // R2
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cand_ready));

  // R2
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (cand_ready & cand_valid & bank_ok) != '0);

  // R10
  pre_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_sel == 2'd3 && cand_valid == bank_ok && $countones(cand_valid) == 1 &&
     cand_cmd[2*int'(grant_idx) +: 2] == 2'd3 && cand_valid[grant_idx]) |-> issue_valid);

endmodule

// File: tb/dram_cmd_arbiter_tb_top.sv
`timescale 1ns/1ps
module dram_cmd_arbiter_tb_top;
  localparam int NR = 2, NB = 4, NQ = 8, AW = 4;
  localparam int BURST = 4, RTRS = 2, TFAW = 12, GMAX = BURST + RTRS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]      pol;
  logic [NQ-1:0]   v, ok;
  logic [1:0]      cmd [NQ];
  logic [AW-1:0]   age [NQ];
  logic [2*NQ-1:0] cmd_f;
  logic [AW*NQ-1:0] age_f;
  logic [NQ-1:0]   rdy;
  logic            iv;
  logic [1:0]      icmd;
  logic            irank;
  logic [1:0]      ibank;

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      cmd_f[2*i +: 2]   = cmd[i];
      age_f[AW*i +: AW] = age[i];
    end
  end

  dram_cmd_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .policy_sel(pol), .cand_valid(v),
    .cand_cmd(cmd_f), .cand_age(age_f), .bank_ok(ok), .cand_ready(rdy),
    .issue_valid(iv), .issue_cmd(icmd), .issue_rank(irank), .issue_bank(ibank)
  );

  int total = 0, bad = 0;
  int gap, last_rank, bptr, rptr;
  int hist [NR][4];
  bit exp_any;
  int exp_idx;

  function automatic bit legal_m(int i);
    int r = i / NB;
    if (!ok[i]) return 0;
    if (cmd[i] == 2'd1 || cmd[i] == 2'd2)
      return gap >= ((r == last_rank) ? BURST : GMAX);
    if (cmd[i] == 2'd0) return hist[r][3] >= TFAW;
    return 1;
  endfunction

  task automatic compute_exp();
    bit f = 0; int s = 0; int best = -1; bit rf = 0; int rs = 0;
    case (pol)
      2'd0, 2'd3: begin
        for (int i = 0; i < NQ; i++)
          if (v[i] && (pol == 2'd0 || legal_m(i)) && int'(age[i]) > best) begin
            best = int'(age[i]); s = i; f = 1;
          end
      end
      2'd1: begin
        for (int k = 0; k < NQ; k++)
          if (!f && v[(bptr + k) % NQ]) begin f = 1; s = (bptr + k) % NQ; end
      end
      default: begin
        for (int k = 0; k < NR; k++)
          if (!rf && (|v[((rptr + k) % NR)*NB +: NB])) begin rf = 1; rs = (rptr + k) % NR; end
        if (rf)
          for (int b = 0; b < NB; b++)
            if (v[rs*NB + b] && int'(age[rs*NB + b]) > best) begin
              best = int'(age[rs*NB + b]); s = rs*NB + b; f = 1;
            end
      end
    endcase
    exp_any = f && legal_m(s);
    exp_idx = s;
  endtask

  task automatic update_model();
    for (int r = 0; r < NR; r++) begin
      if (exp_any && cmd[exp_idx] == 2'd0 && exp_idx / NB == r) begin
        for (int k = 3; k > 0; k--) hist[r][k] = (hist[r][k-1] >= TFAW) ? TFAW : hist[r][k-1] + 1;
        hist[r][0] = 1;
      end else begin
        for (int k = 0; k < 4; k++) hist[r][k] = (hist[r][k] >= TFAW) ? TFAW : hist[r][k] + 1;
      end
    end
    if (exp_any && (cmd[exp_idx] == 2'd1 || cmd[exp_idx] == 2'd2)) begin
      gap = 1; last_rank = exp_idx / NB;
    end else if (gap < GMAX) gap = gap + 1;
    if (exp_any && pol == 2'd1) bptr = (exp_idx + 1) % NQ;
    if (exp_any && pol == 2'd2) rptr = (exp_idx / NB + 1) % NR;
  endtask

  task automatic step(string tag);
    logic [NQ-1:0] ev;
    @(negedge clk);
    compute_exp();
    ev = exp_any ? (NQ'(1) << exp_idx) : '0;
    total++;
    if (rdy !== ev || iv !== exp_any ||
        (exp_any && (icmd !== cmd[exp_idx] || int'(irank) != exp_idx / NB ||
                     int'(ibank) != exp_idx % NB))) begin
      bad++;
      $display("FAIL %s: ready=%b issue=%b cmd=%0d expected ready=%b issue=%b cmd=%0d",
               tag, rdy, iv, icmd, ev, exp_any, exp_any ? cmd[exp_idx] : 2'd0);
    end
    @(posedge clk);
    update_model();
    #1;
  endtask

  task automatic clear_inputs();
    v = '0; ok = '1;
    for (int i = 0; i < NQ; i++) begin cmd[i] = 2'd3; age[i] = '0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pol = 2'd1;
    clear_inputs();
    gap = GMAX; last_rank = 0; bptr = 0; rptr = 0;
    for (int r = 0; r < NR; r++) for (int k = 0; k < 4; k++) hist[r][k] = TFAW;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (rdy !== '0 || iv !== 1'b0) begin
      bad++; $display("FAIL R1: ready=%b issue=%b expected ready=0 issue=0", rdy, iv);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R1: empty after reset, then bank pointer starts at index 0
    step("R1");
    v = '1; step("R1");
    // R8: pointer walks on
    step("R8"); step("R8");
    // R2: nothing bank-ready, nothing granted
    ok = '0; step("R2"); step("R2");
    // R9: rank round robin from rank 0 with ages
    ok = '1; pol = 2'd2;
    for (int i = 0; i < NQ; i++) age[i] = AW'(i * 3 % 7);
    for (int k = 0; k < 4; k++) step("R9");
    // R3: back-to-back reads to one rank
    clear_inputs(); pol = 2'd3;
    v = 8'b0000_0001; cmd[0] = 2'd1;
    for (int k = 0; k < 9; k++) step("R3");
    // R4: switch to the other rank after a read
    v = 8'b0000_0001; step("R4");
    v = 8'b0001_0000; cmd[4] = 2'd2;
    for (int k = 0; k < 8; k++) step("R4");
    // R10: precharge right after a column command
    v = 8'b0000_0010; cmd[1] = 2'd1;
    for (int k = 0; k < 6; k++) step("R10");
    v = 8'b0000_0100; cmd[2] = 2'd3; step("R10");
    v = 8'b0100_0000; cmd[6] = 2'd0; step("R10");
    // R5: a stream of activates to rank 0
    clear_inputs();
    v = 8'b0000_1111;
    for (int i = 0; i < 4; i++) cmd[i] = 2'd0;
    for (int k = 0; k < 20; k++) step("R5");
    // R6/R7: oldest blocked, younger ready
    clear_inputs();
    v = 8'b0000_0011; cmd[0] = 2'd1; cmd[1] = 2'd3; age[0] = 4'd9; age[1] = 4'd2; ok = 8'b1111_1110;
    pol = 2'd0; step("R6");
    pol = 2'd3; step("R7");
    // sweeps over all policies with varied traffic
    for (int p = 0; p < 4; p++) begin
      pol = 2'(p);
      for (int n = 0; n < 1500; n++) begin
        v  = NQ'($urandom);
        ok = NQ'($urandom | $urandom);
        for (int i = 0; i < NQ; i++) begin
          cmd[i] = 2'($urandom);
          age[i] = AW'($urandom);
        end
        case (p)
          0: step("R6");
          1: step("R8");
          2: step("R9");
          default: step("R7");
        endcase
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule